// File: doc/BRIEF.md
# Error Stressing Control Sequencer

This block decides, one unit at a time (a frame or a cell, marked by a unit tick), whether a stress condition is applied to the outgoing stream. A mode input selects one of six behaviours: permanently off, permanently on, a single inverted pulse against an off or on baseline, or a three-phase inverted sequence against an off or on baseline. An arm strobe launches a pulse or sequence. Each phase lasts a programmable number of ticks. When the pattern ends, the block returns to its baseline.

The resulting apply flag drives a small injection datapath. In mask action, the byte flagged as the target is XORed with a user bit mask. In cell-loss action, each cell that starts while the condition applies is replaced by a fill cell. The adaptation sequence number that cell would have carried is consumed, so the data cells show a gap. An overhead slot always carries either the normal or the alternative overhead value, chosen by the same apply flag.

Top module: `err_stress_seq`

## Requirements
- R1: Mode 0 (off) never asserts `apply_o` and mode 1 (on) always asserts it; codes 6 and 7 behave as off.
- R2: Mode 2 (pulse-on) holds `apply_o` low, and after an arm holds it high for one phase, then returns low.
- R3: Mode 3 (pulse-off) holds `apply_o` high, and after an arm holds it low for one phase, then returns high.
- R4: Mode 4 (sequence-on) holds `apply_o` low, and after an arm runs high, low, high (one phase each), then returns low.
- R5: Mode 5 (sequence-off) holds `apply_o` high, and after an arm runs low, high, low (one phase each), then returns high.
- R6: The first phase starts on the clock edge that samples `arm_i`. Every phase lasts `phase_len_i` ticks, and a value of 0 acts as 1. A tick in the arm cycle is not counted.
- R7: An arm received while a pattern runs, or in modes 0 and 1, has no effect on `apply_o`.
- R8: With `action_i`=0 (mask), `apply_o` high and `target_i` high, `byte_o` equals `byte_i ^ mask_i`. In every other case outside the overhead slot, `byte_o` equals `byte_i`.
- R9: When `ovh_slot_i` is high, `byte_o` is `alt_ovh_i` if `apply_o` is high and `normal_ovh_i` otherwise. The overhead slot takes priority over masking.
- R10: On each tick a new cell starts and `sn_o` advances by one (mod 2^SN_W). With `action_i`=1 (loss) and `apply_o` high at that tick, the new cell is a fill cell (`fill_o`=1), so consecutive data cells differ by two.
- R11: After reset, `apply_o` follows the baseline of `mode_i`, `fill_o` is 0 and `sn_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Stress mode code |
| arm_i | input | 1 | Arm strobe, one cycle |
| tick_i | input | 1 | Unit (frame or cell) boundary tick |
| phase_len_i | input | LEN_W | Ticks per phase (0 acts as 1) |
| action_i | input | 1 | 0 = byte mask, 1 = cell loss |
| target_i | input | 1 | Current byte is the chosen header/payload byte |
| ovh_slot_i | input | 1 | Current byte is the stressed overhead byte |
| byte_i | input | DATA_W | Incoming byte |
| mask_i | input | DATA_W | XOR bit mask |
| normal_ovh_i | input | DATA_W | Normal overhead value |
| alt_ovh_i | input | DATA_W | Alternative overhead value |
| apply_o | output | 1 | Stress condition currently applied |
| byte_o | output | DATA_W | Outgoing byte |
| fill_o | output | 1 | Current cell is a fill cell |
| sn_o | output | SN_W | Sequence number of the current cell slot |

## Verification
The pattern engine is tried with both pulse polarities and both sequence polarities, and with phase lengths of 0, 1, 2 and 3 ticks. These runs tell apart the baseline polarity, the phase order, the number of phases and the phase duration, including the zero-length case. An extra arm in the middle of a sequence, and arms in the static modes, show whether re-triggering leaks into the pattern. The datapath is driven with target and non-target bytes, overhead slots, and both actions under applied and idle conditions. These cases separate masking, overhead substitution and the sequence-number gap left by a fill cell.

// File: rtl/stress_pkg.sv
package stress_pkg;
  localparam logic [2:0] MODE_OFF       = 3'd0;
  localparam logic [2:0] MODE_ON        = 3'd1;
  localparam logic [2:0] MODE_PULSE_ON  = 3'd2;
  localparam logic [2:0] MODE_PULSE_OFF = 3'd3;
  localparam logic [2:0] MODE_SEQ_ON    = 3'd4;
  localparam logic [2:0] MODE_SEQ_OFF   = 3'd5;

  localparam logic ACT_MASK = 1'b0;
  localparam logic ACT_LOSS = 1'b1;

  // baseline level of the condition when no pattern runs
  function automatic logic base_on(input logic [2:0] m);
    return (m == MODE_ON) || (m == MODE_PULSE_OFF) || (m == MODE_SEQ_OFF);
  endfunction

  function automatic logic is_pattern(input logic [2:0] m);
    return (m >= MODE_PULSE_ON) && (m <= MODE_SEQ_OFF);
  endfunction

  function automatic logic is_seq(input logic [2:0] m);
    return (m == MODE_SEQ_ON) || (m == MODE_SEQ_OFF);
  endfunction
endpackage

// File: rtl/stress_phase_timer.sv
module stress_phase_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       last_phase_i,
  output logic             active_o,
  output logic [1:0]       phase_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? LEN_W'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      phase_o  <= 2'd0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      phase_o  <= 2'd0;
      cnt_q    <= len_eff;
    end else if (active_o && tick_i) begin
      if (cnt_q == LEN_W'(1)) begin
        if (phase_o == last_phase_i) begin
          active_o <= 1'b0;
          phase_o  <= 2'd0;
          cnt_q    <= '0;
        end else begin
          phase_o <= phase_o + 2'd1;
          cnt_q   <= len_eff;
        end
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

  assert_cnt_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (cnt_q != '0));

  assert_hold_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i && !start_i) |=> ($stable(cnt_q) && $stable(phase_o) && active_o));

  assert_phase_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (phase_o <= 2'd2));

  assert_start_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_o);
endmodule

// File: rtl/stress_byte_path.sv
module stress_byte_path #(
  parameter int DATA_W = 8
) (
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic              mask_en_i,
  input  logic              target_i,
  input  logic              ovh_slot_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] normal_ovh_i,
  input  logic [DATA_W-1:0] alt_ovh_i,
  output logic [DATA_W-1:0] byte_o
);
  logic corrupt;
  assign corrupt = apply_i && mask_en_i && target_i;

  always_comb begin
    if (ovh_slot_i)   byte_o = apply_i ? alt_ovh_i : normal_ovh_i;
    else if (corrupt) byte_o = byte_i ^ mask_i;
    else              byte_o = byte_i;
  end

  always_comb begin
    if (rst_ni && !ovh_slot_i && !apply_i)
      assert_idle_pass_R8: assert (byte_o == byte_i);
    if (rst_ni && !ovh_slot_i && corrupt)
      assert_mask_diff_R8: assert ((byte_o ^ byte_i) == mask_i);
  end
endmodule

// File: rtl/stress_cell_loss.sv
module stress_cell_loss #(
  parameter int SN_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            drop_i,
  output logic            fill_o,
  output logic [SN_W-1:0] sn_o
);
  // every slot consumes a number; a fill slot hides its number from the data stream
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sn_o   <= '1;
      fill_o <= 1'b0;
    end else if (tick_i) begin
      sn_o   <= sn_o + SN_W'(1);
      fill_o <= drop_i;
    end
  end

  assert_sn_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (sn_o == SN_W'($past(sn_o) + SN_W'(1))));

  assert_fill_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(fill_o) && $stable(sn_o)));
endmodule

// File: rtl/err_stress_seq.sv
module err_stress_seq
  import stress_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int SN_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  phase_len_i,
  input  logic              action_i,
  input  logic              target_i,
  input  logic              ovh_slot_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] normal_ovh_i,
  input  logic [DATA_W-1:0] alt_ovh_i,
  output logic              apply_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              fill_o,
  output logic [SN_W-1:0]   sn_o
);
  logic       active;
  logic [1:0] phase;
  logic       start;
  logic [2:0] run_mode_q;
  logic [2:0] eff_mode;
  logic [1:0] last_phase;

  assign start      = arm_i && !active && is_pattern(mode_i);
  assign eff_mode   = active ? run_mode_q : mode_i;
  assign last_phase = is_seq(run_mode_q) ? 2'd2 : 2'd0;
  // phases 0 and 2 invert the baseline, phase 1 restores it
  assign apply_o    = base_on(eff_mode) ^ (active && !phase[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_mode_q <= MODE_OFF;
    else if (start) run_mode_q <= mode_i;
  end

  stress_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .tick_i       (tick_i),
    .len_i        (phase_len_i),
    .last_phase_i (last_phase),
    .active_o     (active),
    .phase_o      (phase)
  );

  stress_byte_path #(.DATA_W(DATA_W)) u_bytes (
    .rst_ni       (rst_ni),
    .apply_i      (apply_o),
    .mask_en_i    (action_i == ACT_MASK),
    .target_i     (target_i),
    .ovh_slot_i   (ovh_slot_i),
    .byte_i       (byte_i),
    .mask_i       (mask_i),
    .normal_ovh_i (normal_ovh_i),
    .alt_ovh_i    (alt_ovh_i),
    .byte_o       (byte_o)
  );

  stress_cell_loss #(.SN_W(SN_W)) u_loss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .drop_i (apply_o && (action_i == ACT_LOSS)),
    .fill_o (fill_o),
    .sn_o   (sn_o)
  );

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && (mode_i == MODE_OFF)) |-> !apply_o);

  assert_on_steady_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && (mode_i == MODE_ON)) |-> apply_o);

  assert_rearm_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && arm_i && !tick_i) |=> (active && $stable(phase) && $stable(apply_o)));

  assert_arm_flips_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (apply_o != $past(base_on(mode_i))));
endmodule

// File: tb/err_stress_seq_test.sv
module err_stress_seq_test;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 8;
  localparam int SN_W   = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        mode_i = 3'd0;
  logic              arm_i = 1'b0;
  logic              tick_i = 1'b0;
  logic [LEN_W-1:0]  phase_len_i = 8'd1;
  logic              action_i = 1'b0;
  logic              target_i = 1'b0;
  logic              ovh_slot_i = 1'b0;
  logic [DATA_W-1:0] byte_i = 8'hA5;
  logic [DATA_W-1:0] mask_i = 8'h0F;
  logic [DATA_W-1:0] normal_ovh_i = 8'h11;
  logic [DATA_W-1:0] alt_ovh_i = 8'h22;
  logic              apply_o;
  logic [DATA_W-1:0] byte_o;
  logic              fill_o;
  logic [SN_W-1:0]   sn_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  err_stress_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SN_W(SN_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .arm_i(arm_i), .tick_i(tick_i),
    .phase_len_i(phase_len_i), .action_i(action_i), .target_i(target_i),
    .ovh_slot_i(ovh_slot_i), .byte_i(byte_i), .mask_i(mask_i),
    .normal_ovh_i(normal_ovh_i), .alt_ovh_i(alt_ovh_i), .apply_o(apply_o),
    .byte_o(byte_o), .fill_o(fill_o), .sn_o(sn_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic arm_once();
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
  endtask

  // generic pattern run: baseline, armed phases, baseline again
  task automatic run_pattern(input string req, input logic [2:0] m, input int len, input bit poke);
    logic base;
    int nph;
    int leff;
    mode_i = m;
    phase_len_i = LEN_W'(len);
    @(negedge clk);
    base = (m == 3'd1) || (m == 3'd3) || (m == 3'd5);
    nph  = (m >= 3'd4) ? 3 : 1;
    leff = (len == 0) ? 1 : len;
    check({req, " baseline"}, 32'(apply_o), 32'(base));
    arm_once();
    for (int p = 0; p < nph; p++) begin
      for (int k = 0; k < leff; k++) begin
        if (poke && (p == 1) && (k == 0)) arm_once();  // R7 re-arm mid run
        check({req, " phase"}, 32'(apply_o), 32'(base ^ ((p % 2) == 0)));
        tick_once();
      end
    end
    check({req, " end baseline"}, 32'(apply_o), 32'(base));
    tick_once();
    check({req, " stays baseline"}, 32'(apply_o), 32'(base));
  endtask

  task automatic test_reset();
    check("R11 apply", 32'(apply_o), 32'd0);
    check("R11 fill", 32'(fill_o), 32'd0);
    check("R11 sn", 32'(sn_o), 32'h7);
    check("R11 byte", 32'(byte_o), 32'hA5);
  endtask

  task automatic test_static();
    mode_i = 3'd1; @(negedge clk);
    check("R1 on", 32'(apply_o), 32'd1);
    arm_once(); tick_once();
    check("R7 arm in on", 32'(apply_o), 32'd1);
    mode_i = 3'd0; @(negedge clk);
    check("R1 off", 32'(apply_o), 32'd0);
    arm_once(); tick_once();
    check("R7 arm in off", 32'(apply_o), 32'd0);
    mode_i = 3'd6; arm_once(); tick_once();
    check("R1 code 6 off", 32'(apply_o), 32'd0);
  endtask

  task automatic test_tick_in_arm_cycle();
    // R6: tick coinciding with arm is not counted
    mode_i = 3'd2; phase_len_i = 8'd1;
    @(negedge clk) begin arm_i = 1'b1; tick_i = 1'b1; end
    @(negedge clk) begin arm_i = 1'b0; tick_i = 1'b0; end
    check("R6 arm+tick", 32'(apply_o), 32'd1);
    tick_once();
    check("R6 after one tick", 32'(apply_o), 32'd0);
  endtask

  task automatic test_bytes();
    action_i = 1'b0; target_i = 1'b1; ovh_slot_i = 1'b0;
    mode_i = 3'd1; @(negedge clk);
    check("R8 mask applied", 32'(byte_o), 32'hAA);
    target_i = 1'b0; @(negedge clk);
    check("R8 non-target", 32'(byte_o), 32'hA5);
    target_i = 1'b1; mode_i = 3'd0; @(negedge clk);
    check("R8 idle target", 32'(byte_o), 32'hA5);
    mode_i = 3'd1; action_i = 1'b1; @(negedge clk);
    check("R8 loss action no mask", 32'(byte_o), 32'hA5);
    action_i = 1'b0; ovh_slot_i = 1'b1; @(negedge clk);
    check("R9 alt ovh", 32'(byte_o), 32'h22);
    mode_i = 3'd0; @(negedge clk);
    check("R9 normal ovh", 32'(byte_o), 32'h11);
    ovh_slot_i = 1'b0; target_i = 1'b0;
  endtask

  task automatic test_loss();
    logic [SN_W-1:0] a;
    mode_i = 3'd1; action_i = 1'b0; tick_once();
    check("R10 mask action no fill", 32'(fill_o), 32'd0);
    mode_i = 3'd2; phase_len_i = 8'd1; action_i = 1'b1;
    tick_once();
    a = sn_o;
    check("R10 data before", 32'(fill_o), 32'd0);
    arm_once();
    tick_once();
    check("R10 fill cell", 32'(fill_o), 32'd1);
    check("R10 fill slot sn", 32'(sn_o), 32'(SN_W'(a + 3'd1)));
    tick_once();
    check("R10 data after", 32'(fill_o), 32'd0);
    check("R10 data gap", 32'(SN_W'(sn_o - a)), 32'd2);
    action_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_static();
    run_pattern("R2", 3'd2, 3, 1'b0);
    run_pattern("R3", 3'd3, 2, 1'b0);
    run_pattern("R4", 3'd4, 2, 1'b1);
    run_pattern("R5", 3'd5, 1, 1'b0);
    run_pattern("R6 len0", 3'd4, 0, 1'b0);
    test_tick_in_arm_cycle();
    test_bytes();
    test_loss();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule